// File: doc/BRIEF.md
# Power-down controller with reset wake

This block manages the deepest sleep state of a small 8-bit microcontroller core. The core writes a byte-wide power-control register. The register cannot be bit-addressed, so firmware sets the sleep request flag (bit 1) by reading the byte, ORing in 0x02 and writing the whole byte back. The write that sets the flag is the last one the core completes. On the next clock edge the block does four things: it stops the core clock, drops its oscillator-enable output, freezes the output pins at the values they had during that final write cycle, and drives the address-latch and program-fetch strobes low.

Nothing but a hardware reset brings the block out of power-down. The reset puts the control register back to its initial value, turns the oscillator on again and pulses a clear line to the special function registers. It raises a RAM-retain flag so that the on-chip memory keeps its contents. The core is held in reset for a parameterised number of oscillator cycles after the external reset is released, which gives the restarted oscillator time to settle.

Top module: `power_down_ctl`

## Requirements
- R1: While reset is asserted and after the first clock edge with reset asserted, the block shows: the control register reads 0x00, `pd_status`=0, `osc_en`=1, `core_clk_en`=1, and every bit of `pin_out` is 1.
- R2: A write (`reg_wr_en`=1) while not powered down stores the whole byte, which `reg_rd_data` shows after the next edge. A byte with bit 1 equal to 0 does not enter power-down.
- R3: A write with bit 1 set while running makes `pd_status`=1, `osc_en`=0 and `core_clk_en`=0 after the next clock edge.
- R4: While running, each `pin_out` bit equals, one cycle later, `alt_val` for that bit if its `alt_sel` bit is 1, and `latch_val` otherwise.
- R5: While powered down, `pin_out` holds the value selected per R4 from the inputs present in the cycle of the entering write. Later changes of `latch_val`, `alt_val` and `alt_sel` have no effect.
- R6: While running, `ale_out` and `psen_out` follow `ale_in` and `psen_in` one cycle later. From the edge that enters power-down until reset they are 0.
- R7: While powered down, register writes are ignored: neither `reg_rd_data` nor `pd_status` changes. `pd_status` stays 1 until reset.
- R8: Reset clears the control register, including bit 1, and sets `pd_status` to 0 and `osc_en` to 1. `sfr_clr` is 1 while reset is asserted and 0 from the first edge after release.
- R9: `core_rst` is 1 during reset and stays 1 for exactly STAB_CYCLES clock edges after reset is released. It becomes 0 at the STAB_CYCLES-th edge with reset low.
- R10: `ram_retain` is 1 while powered down and while `core_rst` is 1, and 0 during normal running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr_en | input | 1 | Byte write strobe for the control register |
| reg_wr_data | input | 8 | Byte written to the control register |
| reg_rd_data | output | 8 | Current control register contents |
| latch_val | input | PINS | Port latch values |
| alt_val | input | PINS | Alternate-function output values |
| alt_sel | input | PINS | Per pin: 1 selects the alternate function |
| ale_in | input | 1 | Address latch strobe from the core |
| psen_in | input | 1 | Program fetch strobe from the core |
| pin_out | output | PINS | Pin drive values |
| ale_out | output | 1 | Address latch strobe to the pad |
| psen_out | output | 1 | Program fetch strobe to the pad |
| pd_status | output | 1 | High while powered down |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| core_rst | output | 1 | Core reset, extended for oscillator settling |
| sfr_clr | output | 1 | Clear pulse for special function registers |
| ram_retain | output | 1 | On-chip RAM must keep its contents |

## Verification
The hardest behaviour to reach is the pin freeze. It hinges on the single cycle of the entering write, and afterwards it must survive input activity that a real stopped core would never produce. The bench carries out the read-modify-write sequence with a distinctive pin pattern on the inputs during the write cycle. It then drives different latch, alternate and strobe values, plus a write that clears bit 1, and checks that the frozen pins, the low strobes and the power-down state all stay unchanged. The settling window is measured edge by edge after each of two resets, one of them taken from power-down.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int REG_W   = 8;
  localparam int PDE_BIT = 1;

  typedef enum logic {
    PM_RUN  = 1'b0,
    PM_DOWN = 1'b1
  } pm_state_t;
endpackage

// File: rtl/pdc_ctrl_reg.sv
module pdc_ctrl_reg
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             enter,
  output logic             down
);
  pm_state_t        state_q;
  logic [REG_W-1:0] reg_q;

  assign enter   = wr_en && wr_data[PDE_BIT] && (state_q == PM_RUN);
  assign down    = (state_q == PM_DOWN);
  assign rd_data = reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      state_q <= PM_RUN;
    end else if (state_q == PM_RUN) begin
      if (wr_en) reg_q <= wr_data;
      if (enter) state_q <= PM_DOWN;
    end
  end
endmodule

// File: rtl/pdc_pin_freeze.sv
module pdc_pin_freeze #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            pd_next,
  input  logic [PINS-1:0] latch_val,
  input  logic [PINS-1:0] alt_val,
  input  logic [PINS-1:0] alt_sel,
  input  logic            ale_in,
  input  logic            psen_in,
  output logic [PINS-1:0] pin_out,
  output logic            ale_out,
  output logic            psen_out
);
  logic [PINS-1:0] live;
  logic [PINS-1:0] cap_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign live[i] = alt_sel[i] ? alt_val[i] : latch_val[i];

    always_ff @(posedge clk) begin
      if (rst)       cap_q[i] <= 1'b1;
      else if (!hold) cap_q[i] <= live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_out  <= 1'b0;
      psen_out <= 1'b0;
    end else begin
      ale_out  <= ale_in  && !pd_next;
      psen_out <= psen_in && !pd_next;
    end
  end

  assign pin_out = cap_q;
endmodule

// File: rtl/pdc_stab_timer.sv
module pdc_stab_timer #(
  parameter int STAB_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic core_rst,
  output logic core_rst_next,
  output logic sfr_clr
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt       = (cnt_q == LIM) ? cnt_q : cnt_q + CW'(1);
  assign core_rst_next = rst || (cnt_nxt != LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      core_rst <= 1'b1;
      sfr_clr  <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      core_rst <= (cnt_nxt != LIM);
      sfr_clr  <= 1'b0;
    end
  end
endmodule

// File: rtl/power_down_ctl.sv
module power_down_ctl #(
  parameter int PINS        = 8,
  parameter int STAB_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [7:0]      reg_wr_data,
  output logic [7:0]      reg_rd_data,
  input  logic [PINS-1:0] latch_val,
  input  logic [PINS-1:0] alt_val,
  input  logic [PINS-1:0] alt_sel,
  input  logic            ale_in,
  input  logic            psen_in,
  output logic [PINS-1:0] pin_out,
  output logic            ale_out,
  output logic            psen_out,
  output logic            pd_status,
  output logic            osc_en,
  output logic            core_clk_en,
  output logic            core_rst,
  output logic            sfr_clr,
  output logic            ram_retain
);
  logic enter;
  logic down;
  logic pd_next;
  logic core_rst_next;

  assign pd_next = down || enter;

  pdc_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .rd_data (reg_rd_data),
    .enter   (enter),
    .down    (down)
  );

  pdc_pin_freeze #(.PINS(PINS)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .hold      (down),
    .pd_next   (pd_next),
    .latch_val (latch_val),
    .alt_val   (alt_val),
    .alt_sel   (alt_sel),
    .ale_in    (ale_in),
    .psen_in   (psen_in),
    .pin_out   (pin_out),
    .ale_out   (ale_out),
    .psen_out  (psen_out)
  );

  pdc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk           (clk),
    .rst           (rst),
    .core_rst      (core_rst),
    .core_rst_next (core_rst_next),
    .sfr_clr       (sfr_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en      <= 1'b1;
      core_clk_en <= 1'b1;
      ram_retain  <= 1'b1;
    end else begin
      osc_en      <= !pd_next;
      core_clk_en <= !pd_next;
      ram_retain  <= pd_next || core_rst_next;
    end
  end

  assign pd_status = down;
endmodule

// File: rtl/power_down_ctl_chk.sv
module power_down_ctl_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr_en,
  input logic [7:0]      reg_wr_data,
  input logic [7:0]      reg_rd_data,
  input logic [PINS-1:0] pin_out,
  input logic            ale_out,
  input logic            psen_out,
  input logic            pd_status,
  input logic            osc_en,
  input logic            core_clk_en,
  input logic            core_rst,
  input logic            sfr_clr,
  input logic            ram_retain
);
  // R3
  a_r3_enter: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[1] && !pd_status) |=> (pd_status && !osc_en && !core_clk_en));
  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    pd_status |=> (pd_status && $stable(reg_rd_data)));
  // R5
  a_r5_pin_hold: assert property (@(posedge clk) disable iff (rst)
    pd_status |=> $stable(pin_out));
  // R6
  a_r6_strobes_low: assert property (@(posedge clk) disable iff (rst)
    pd_status |-> (!ale_out && !psen_out));
  // R10
  a_r10_retain: assert property (@(posedge clk) disable iff (rst)
    (pd_status || core_rst) |-> ram_retain);
  // R9
  a_r9_release_after_rst: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(!rst));
  // R8
  a_r8_clr_in_reset: assert property (@(posedge clk) disable iff (rst)
    sfr_clr |-> core_rst);
endmodule

bind power_down_ctl power_down_ctl_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .pin_out     (pin_out),
  .ale_out     (ale_out),
  .psen_out    (psen_out),
  .pd_status   (pd_status),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .core_rst    (core_rst),
  .sfr_clr     (sfr_clr),
  .ram_retain  (ram_retain)
);

// File: tb/power_down_ctl_bench.sv
`timescale 1ns/1ps
module power_down_ctl_bench;
  localparam int PINS = 8;
  localparam int STAB = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic [PINS-1:0] latch_val = '0, alt_val = '0, alt_sel = '0;
  logic ale_in = 1'b0, psen_in = 1'b0;
  logic [PINS-1:0] pin_out;
  logic ale_out, psen_out, pd_status, osc_en, core_clk_en, core_rst, sfr_clr, ram_retain;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  power_down_ctl #(.PINS(PINS), .STAB_CYCLES(STAB)) u_power_down_ctl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .latch_val(latch_val), .alt_val(alt_val),
    .alt_sel(alt_sel), .ale_in(ale_in), .psen_in(psen_in), .pin_out(pin_out),
    .ale_out(ale_out), .psen_out(psen_out), .pd_status(pd_status),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .core_rst(core_rst),
    .sfr_clr(sfr_clr), .ram_retain(ram_retain)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] sel_pins(input logic [PINS-1:0] l, input logic [PINS-1:0] a,
                                                input logic [PINS-1:0] s);
    return (a & s) | (l & ~s);
  endfunction

  task automatic do_reset_and_settle(input string ctx);
    rst = 1'b1;
    reg_wr_en = 1'b0;
    tick(); tick(); tick();
    chk({"R1 rd ", ctx}, reg_rd_data, 8'h00);
    chk({"R1 pd ", ctx}, pd_status, 1'b0);
    chk({"R8 osc_en ", ctx}, osc_en, 1'b1);
    chk({"R1 clk_en ", ctx}, core_clk_en, 1'b1);
    chk({"R1 pins ", ctx}, pin_out, {PINS{1'b1}});
    chk({"R8 sfr_clr ", ctx}, sfr_clr, 1'b1);
    chk({"R9 core_rst in reset ", ctx}, core_rst, 1'b1);
    chk({"R10 retain in reset ", ctx}, ram_retain, 1'b1);
    rst = 1'b0;
    tick();
    chk({"R8 sfr_clr released ", ctx}, sfr_clr, 1'b0);
    for (int i = 1; i < STAB - 1; i++) tick();
    chk({"R9 core_rst before limit ", ctx}, core_rst, 1'b1);
    chk({"R10 retain in settle ", ctx}, ram_retain, 1'b1);
    tick();
    chk({"R9 core_rst at limit ", ctx}, core_rst, 1'b0);
    chk({"R10 retain running ", ctx}, ram_retain, 1'b0);
  endtask

  task automatic t_write();
    reg_wr_en = 1'b1; reg_wr_data = 8'hA5;
    tick();
    reg_wr_en = 1'b0;
    chk("R2 byte stored A5", reg_rd_data, 8'hA5);
    chk("R2 bit1 clear stays running", pd_status, 1'b0);
    reg_wr_en = 1'b1; reg_wr_data = 8'h58;
    tick();
    reg_wr_en = 1'b0;
    chk("R2 byte stored 58", reg_rd_data, 8'h58);
    chk("R2 osc stays on", osc_en, 1'b1);
  endtask

  task automatic t_pins();
    logic [PINS-1:0] l [3] = '{8'h3C, 8'hFF, 8'h00};
    logic [PINS-1:0] a [3] = '{8'hA0, 8'h00, 8'h5A};
    logic [PINS-1:0] s [3] = '{8'h0F, 8'hF0, 8'hFF};
    for (int k = 0; k < 3; k++) begin
      latch_val = l[k]; alt_val = a[k]; alt_sel = s[k];
      ale_in = k[0]; psen_in = !k[0];
      tick();
      chk("R4 pin mux", pin_out, sel_pins(l[k], a[k], s[k]));
      chk("R6 ale follows", ale_out, k[0]);
      chk("R6 psen follows", psen_out, !k[0]);
    end
  endtask

  task automatic t_enter_and_hold();
    logic [7:0] rmw;
    logic [PINS-1:0] frozen;
    rmw = reg_rd_data | 8'h02;
    latch_val = 8'hC3; alt_val = 8'h96; alt_sel = 8'h3C;
    ale_in = 1'b1; psen_in = 1'b1;
    frozen = sel_pins(8'hC3, 8'h96, 8'h3C);
    reg_wr_en = 1'b1; reg_wr_data = rmw;
    tick();
    reg_wr_en = 1'b0;
    chk("R3 pd_status", pd_status, 1'b1);
    chk("R3 osc_en off", osc_en, 1'b0);
    chk("R3 clk_en off", core_clk_en, 1'b0);
    chk("R5 frozen pins", pin_out, frozen);
    chk("R6 ale low", ale_out, 1'b0);
    chk("R6 psen low", psen_out, 1'b0);
    chk("R10 retain in pd", ram_retain, 1'b1);
    latch_val = 8'h0F; alt_val = 8'hF0; alt_sel = 8'h55;
    tick(); tick();
    chk("R5 pins ignore inputs", pin_out, frozen);
    chk("R6 strobes stay low", {ale_out, psen_out}, 2'b00);
    reg_wr_en = 1'b1; reg_wr_data = 8'h00;
    tick();
    reg_wr_en = 1'b0;
    tick();
    chk("R7 write ignored rd", reg_rd_data, rmw);
    chk("R7 still powered down", pd_status, 1'b1);
    chk("R7 osc still off", osc_en, 1'b0);
    chk("R5 pins after write", pin_out, frozen);
  endtask

  initial begin
    fork
      begin
        do_reset_and_settle("cold");
        t_write();
        t_pins();
        t_enter_and_hold();
        do_reset_and_settle("wake");
        chk("R8 bit1 cleared", reg_rd_data[1], 1'b0);
        t_pins();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule